// File: doc/BRIEF.md
# Flash Program/Erase Polling Engine

This block sits on the host side of a parallel NOR-style flash bus. It handles one write operation for each start pulse: a byte program, a sector erase or a whole-chip erase. For the chosen operation it sends the unlock-and-command write sequence. It then reads the device status until the operation ends, and reports the result on a done pulse with a pass or fail flag.

Completion can be found in two ways, chosen by a mode input. In data-polling mode the engine compares status bit 7 with the expected value. In toggle mode it reads in pairs and looks for status bit 6 changing between the two reads. In both modes a set bit 5 (the device's time-limit flag) is not enough to fail the operation. The engine reads again to confirm, because the other status bit may settle in the same cycle. When an operation fails, the engine writes F0h so that the device returns to array-read mode. A poll-limit parameter caps the number of status reads, so a hung device cannot stall the engine.

Top module: `flash_poll_engine`

## Requirements
- R1: After synchronous reset, `done`, `pass`, `fail`, `bus_wr` and `bus_rd` are all 0.
- R2: A start with `op`=0 (byte program) produces four writes in this order: AAh at 555h, 55h at 2AAh, A0h at 555h, then `data` at `addr`.
- R3: A start with `op`=1 (sector erase) produces six writes in this order: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h at `addr`.
- R4: A start with `op`=2 (chip erase) produces the same first five writes as R3, followed by 10h at 555h.
- R5: Each bus access is a one-cycle strobe. `bus_wr` and `bus_rd` are never high together. Every status read uses `addr`. Read data is captured at the clock edge that ends the cycle in which `bus_rd` is high.
- R6: With `mode`=0 (data polling), a read whose bit 7 equals the expected bit (bit 7 of `data` for a program, 1 for an erase) marks completion. A mismatch with bit 5 clear starts another poll.
- R7: With `mode`=0, a mismatch with bit 5 set triggers one more read. Only a second bit-7 mismatch on that read is a failure.
- R8: With `mode`=1 (toggle), status is read in pairs. If bit 6 is equal in both reads of a pair, the operation has completed. If bit 6 differs and bit 5 of the second read is clear, the engine polls another pair.
- R9: With `mode`=1, a toggling pair with bit 5 set triggers one more pair. The engine fails only if bit 6 still toggles in that pair.
- R10: On completion, a program passes only if the read byte equals `data`, and an erase passes only if it equals FFh. Otherwise the operation fails.
- R11: When a poll round ends without a verdict and `POLL_LIMIT` status reads have been made, the operation fails.
- R12: Every failure writes F0h once before reporting. `done` is high for exactly one cycle, with exactly one of `pass`/`fail` set. `pass`/`fail` hold until the next accepted start.
- R13: A start is ignored while an operation is running, and a start with `op`=3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 none |
| mode | input | 1 | 0 data polling, 1 toggle detection |
| addr | input | ADDR_W | Target / sector / poll address |
| data | input | 8 | Byte to program |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation succeeded |
| fail | output | 1 | Operation failed |
| bus_addr | output | ADDR_W | Flash bus address |
| bus_wdata | output | 8 | Flash bus write data |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 8 | Flash bus read data |

## Verification
The bench builds the engine with `ADDR_W`=12 and `POLL_LIMIT`=6. This keeps the timeout path only six reads away, and the 555h/2AAh unlock addresses still fit in the address width. A scripted device model returns status bytes and records every write. This covers each op code in both modes, both recheck outcomes, wrong final bytes and the timeout. A sweep over program data values checks that the expected bit 7 follows the data in data-polling mode.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_SECT = 2'd1, OP_CHIP = 2'd2, OP_NONE = 2'd3} op_e;
  typedef enum logic [2:0] {V_MORE, V_AGAIN, V_CONFIRM, V_PASS, V_FAIL} verdict_e;
  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ISSUE, S_CAP, S_RST} state_e;
  localparam int STEP_W = 3;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int UNLOCK_A = 'h555,
  parameter int UNLOCK_B = 'h2AA
) (
  input  op_e                 op,
  input  logic [STEP_W-1:0]   step,
  input  logic [ADDR_W-1:0]   tgt_addr,
  input  logic [BYTE_W-1:0]   tgt_data,
  output logic [ADDR_W-1:0]   wa,
  output logic [BYTE_W-1:0]   wd,
  output logic                last
);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(UNLOCK_A);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(UNLOCK_B);

  logic is_prog;
  assign is_prog = (op == OP_PROG);
  assign last    = is_prog ? (step == STEP_W'(3)) : (step == STEP_W'(5));

  always_comb begin
    wa = A_HI;
    wd = 8'hAA;
    case (step)
      STEP_W'(0): begin wa = A_HI; wd = 8'hAA; end
      STEP_W'(1): begin wa = A_LO; wd = 8'h55; end
      STEP_W'(2): begin wa = A_HI; wd = is_prog ? 8'hA0 : 8'h80; end
      STEP_W'(3): begin
        wa = is_prog ? tgt_addr : A_HI;
        wd = is_prog ? tgt_data : 8'hAA;
      end
      STEP_W'(4): begin wa = A_LO; wd = 8'h55; end
      default: begin
        wa = (op == OP_SECT) ? tgt_addr : A_HI;
        wd = (op == OP_SECT) ? 8'h30 : 8'h10;
      end
    endcase
  end
endmodule

// File: rtl/flash_status_eval.sv
module flash_status_eval
  import flash_poll_pkg::*;
(
  input  logic              toggle_mode,
  input  logic              erase,
  input  logic [BYTE_W-1:0] exp_byte,
  input  logic [BYTE_W-1:0] cur,
  input  logic [BYTE_W-1:0] prev,
  input  logic              second,
  input  logic              confirm,
  output verdict_e          verdict
);
  logic exp7, finished, good;

  assign exp7 = erase ? 1'b1 : exp_byte[7];
  assign good = erase ? (cur == 8'hFF) : (cur == exp_byte);
  assign finished = toggle_mode ? (prev[6] == cur[6]) : (cur[7] == exp7);

  always_comb begin
    if (toggle_mode && !second) verdict = V_MORE;
    else if (finished)          verdict = good ? V_PASS : V_FAIL;
    else if (confirm)           verdict = V_FAIL;
    else if (cur[5])            verdict = V_CONFIRM;
    else                        verdict = V_AGAIN;
  end
endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int POLL_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic              mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic [7:0]        bus_rdata
);
  localparam int CNT_W = $clog2(POLL_LIMIT + 2);

  state_e              state;
  op_e                 op_q;
  logic                mode_q, half, second, confirm;
  logic [ADDR_W-1:0]   addr_q;
  logic [7:0]          data_q, prev_q;
  logic [STEP_W-1:0]   step;
  logic [CNT_W-1:0]    cnt, cnt_nx;
  logic [ADDR_W-1:0]   seq_a;
  logic [7:0]          seq_d;
  logic                seq_last;
  verdict_e            verdict;

  assign cnt_nx = cnt + CNT_W'(1);

  flash_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .op(op_q), .step(step), .tgt_addr(addr_q), .tgt_data(data_q),
    .wa(seq_a), .wd(seq_d), .last(seq_last)
  );

  flash_status_eval u_eval (
    .toggle_mode(mode_q), .erase(op_q != OP_PROG), .exp_byte(data_q),
    .cur(bus_rdata), .prev(prev_q), .second(second), .confirm(confirm),
    .verdict(verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; op_q <= OP_PROG; mode_q <= 1'b0; addr_q <= '0;
      data_q <= '0; prev_q <= '0; step <= '0; half <= 1'b0; cnt <= '0;
      second <= 1'b0; confirm <= 1'b0; done <= 1'b0; pass <= 1'b0;
      fail <= 1'b0; bus_addr <= '0; bus_wdata <= '0; bus_wr <= 1'b0;
      bus_rd <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start && op != 2'd3) begin
          op_q <= op_e'(op); mode_q <= mode; addr_q <= addr; data_q <= data;
          step <= '0; half <= 1'b0; cnt <= '0; second <= 1'b0;
          confirm <= 1'b0; pass <= 1'b0; fail <= 1'b0; state <= S_CMD;
        end
        S_CMD: if (!half) begin
          bus_wr <= 1'b1; bus_addr <= seq_a; bus_wdata <= seq_d; half <= 1'b1;
        end else begin
          bus_wr <= 1'b0; half <= 1'b0;
          if (seq_last) state <= S_ISSUE;
          else step <= step + STEP_W'(1);
        end
        S_ISSUE: begin
          bus_rd <= 1'b1; bus_addr <= addr_q; state <= S_CAP;
        end
        S_CAP: begin
          bus_rd <= 1'b0;
          cnt <= cnt_nx;
          case (verdict)
            V_MORE:    begin prev_q <= bus_rdata; second <= 1'b1; state <= S_ISSUE; end
            V_CONFIRM: begin confirm <= 1'b1; second <= 1'b0; state <= S_ISSUE; end
            V_AGAIN: begin
              second <= 1'b0;
              state <= (cnt_nx >= CNT_W'(POLL_LIMIT)) ? S_RST : S_ISSUE;
            end
            V_PASS:  begin done <= 1'b1; pass <= 1'b1; state <= S_IDLE; end
            default: state <= S_RST;
          endcase
        end
        S_RST: if (!half) begin
          bus_wr <= 1'b1; bus_addr <= '0; bus_wdata <= 8'hF0; half <= 1'b1;
        end else begin
          bus_wr <= 1'b0; half <= 1'b0; done <= 1'b1; fail <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5: strobes never overlap and each lasts one cycle
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst) !(bus_wr && bus_rd));
  p_wr_pulse_r5: assert property (@(posedge clk) disable iff (rst) bus_wr |=> !bus_wr);
  p_rd_pulse_r5: assert property (@(posedge clk) disable iff (rst) bus_rd |=> !bus_rd);
  // R5: status reads go to the latched target address
  p_poll_addr_r5: assert property (@(posedge clk) disable iff (rst) bus_rd |-> bus_addr == addr_q);
  // R12: done carries exactly one verdict and is a single pulse
  p_done_verdict_r12: assert property (@(posedge clk) disable iff (rst) done |-> (pass ^ fail));
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R12: a failure is reported right after the F0h write
  p_fail_reset_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> ($past(bus_wr) && $past(bus_wdata) == 8'hF0));
endmodule

// File: tb/flash_poll_engine_bench.sv
module flash_poll_engine_bench;
  localparam int AW = 12;
  localparam int LIM = 6;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, mode = 1'b0;
  logic [1:0] op = 2'd0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0, bus_rdata = '0, bus_wdata;
  logic [AW-1:0] bus_addr;
  logic done, pass, fail, bus_wr, bus_rd;

  flash_poll_engine #(.ADDR_W(AW), .POLL_LIMIT(LIM)) u_flash_poll_engine (
    .clk(clk), .rst(rst), .start(start), .op(op), .mode(mode), .addr(addr),
    .data(data), .done(done), .pass(pass), .fail(fail), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  logic [7:0] scr [0:7];
  int scr_len = 1, rcnt = 0, wcnt = 0, bad_pa = 0, done_cnt = 0;
  logic [AW-1:0] wlog_a [0:7];
  logic [7:0] wlog_d [0:7];
  logic [AW-1:0] exp_pa = '0;

  // device model: acts away from the active edge
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (bus_wr) begin
      if (wcnt < 8) begin wlog_a[wcnt] = bus_addr; wlog_d[wcnt] = bus_wdata; end
      wcnt++;
    end
    if (bus_rd) begin
      if (bus_addr != exp_pa) bad_pa++;
      bus_rdata = (rcnt < scr_len) ? scr[rcnt] : scr[scr_len-1];
      rcnt++;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic set_scr(input int n, input logic [7:0] b0, b1, b2, b3, b4, b5);
    scr[0] = b0; scr[1] = b1; scr[2] = b2; scr[3] = b3; scr[4] = b4; scr[5] = b5;
    scr_len = n;
  endtask

  function automatic int seq_len(input logic [1:0] o);
    return (o == 2'd0) ? 4 : 6;
  endfunction

  // expected write i per R2/R3/R4, then F0h per R12
  task automatic exp_write(input logic [1:0] o, input logic [AW-1:0] a, input logic [7:0] d,
                           input int i, output logic [AW-1:0] ea, output logic [7:0] ed);
    if (i >= seq_len(o)) begin ea = '0; ed = 8'hF0; end
    else if (o == 2'd0) begin
      case (i)
        0: begin ea = 'h555; ed = 8'hAA; end
        1: begin ea = 'h2AA; ed = 8'h55; end
        2: begin ea = 'h555; ed = 8'hA0; end
        default: begin ea = a; ed = d; end
      endcase
    end else begin
      case (i)
        0, 3: begin ea = 'h555; ed = 8'hAA; end
        1, 4: begin ea = 'h2AA; ed = 8'h55; end
        2: begin ea = 'h555; ed = 8'h80; end
        default: begin
          ea = (o == 2'd1) ? a : 'h555;
          ed = (o == 2'd1) ? 8'h30 : 8'h10;
        end
      endcase
    end
  endtask

  task automatic run(input logic [1:0] o, input logic m, input logic [AW-1:0] a,
                     input logic [7:0] d, input int exp_reads, input logic exp_pass,
                     input logic poke, input string tag);
    logic seen;
    logic [AW-1:0] ea;
    logic [7:0] ed;
    int nw;
    rcnt = 0; wcnt = 0; bad_pa = 0; done_cnt = 0; exp_pa = a; seen = 1'b0;
    @(negedge clk);
    start = 1'b1; op = o; mode = m; addr = a; data = d;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 300 && !seen; k++) begin
      if (poke && k == 3) begin start = 1'b1; op = 2'd2; addr = a ^ 'h0F0; end
      if (poke && k == 4) start = 1'b0;
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        chk(pass == exp_pass, {tag, " R10 pass"}, pass, exp_pass);
        chk(fail == !exp_pass, {tag, " R12 fail"}, fail, !exp_pass);
      end
    end
    chk(seen, {tag, " R12 done seen"}, seen, 1);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, {tag, " R12 one done pulse"}, done_cnt, 1);
    chk(pass == exp_pass && fail == !exp_pass, {tag, " R12 flags held"}, {pass, fail}, {exp_pass, !exp_pass});
    chk(rcnt == exp_reads, {tag, " R6/R8 read count"}, rcnt, exp_reads);
    chk(bad_pa == 0, {tag, " R5 poll address"}, bad_pa, 0);
    nw = seq_len(o) + (exp_pass ? 0 : 1);
    chk(wcnt == nw, {tag, " R2/R3/R4/R12 write count"}, wcnt, nw);
    for (int i = 0; i < nw && i < wcnt; i++) begin
      exp_write(o, a, d, i, ea, ed);
      chk(wlog_a[i] == ea && wlog_d[i] == ed, {tag, " R2/R3/R4 write"},
          {wlog_a[i], wlog_d[i]}, {ea, ed});
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({done, pass, fail, bus_wr, bus_rd} == 5'b0, "R1 reset state",
        {done, pass, fail, bus_wr, bus_rd}, 0);

    // R2 R6: data polling program, two busy reads then true data
    set_scr(3, 8'h80, 8'h80, 8'h5A, 0, 0, 0);
    run(2'd0, 1'b0, 12'h3C1, 8'h5A, 3, 1'b1, 1'b0, "R2 R6 prog poll");
    // R8 R13: toggle program, second start mid-run ignored
    set_scr(6, 8'h00, 8'h40, 8'h00, 8'h40, 8'hA5, 8'hA5);
    run(2'd0, 1'b1, 12'h0A7, 8'hA5, 6, 1'b1, 1'b1, "R8 R13 prog toggle");
    // R3 R6: sector erase data polling
    set_scr(2, 8'h00, 8'hFF, 0, 0, 0, 0);
    run(2'd1, 1'b0, 12'hE00, 8'h00, 2, 1'b1, 1'b0, "R3 sector poll");
    // R4 R8: chip erase toggle
    set_scr(4, 8'h00, 8'h40, 8'hFF, 8'hFF, 0, 0);
    run(2'd2, 1'b1, 12'h123, 8'h00, 4, 1'b1, 1'b0, "R4 chip toggle");
    // R7: bit 5 with recheck that matches
    set_scr(2, 8'h20, 8'h80, 0, 0, 0, 0);
    run(2'd0, 1'b0, 12'h010, 8'h80, 2, 1'b1, 1'b0, "R7 recheck ok");
    // R7 R12: recheck mismatch fails with F0h
    set_scr(2, 8'h20, 8'h20, 0, 0, 0, 0);
    run(2'd0, 1'b0, 12'h011, 8'h80, 2, 1'b0, 1'b0, "R7 recheck fail");
    // R9: toggling with bit 5, next pair settled
    set_scr(4, 8'h00, 8'h60, 8'hFF, 8'hFF, 0, 0);
    run(2'd2, 1'b1, 12'h200, 8'h00, 4, 1'b1, 1'b0, "R9 settle");
    // R9 R12: still toggling fails
    set_scr(4, 8'h00, 8'h60, 8'h00, 8'h40, 0, 0);
    run(2'd1, 1'b1, 12'h400, 8'h00, 4, 1'b0, 1'b0, "R9 toggle fail");
    // R11: device never finishes
    set_scr(1, 8'h80, 0, 0, 0, 0, 0);
    run(2'd0, 1'b0, 12'h777, 8'h00, LIM, 1'b0, 1'b0, "R11 timeout");
    // R10: erase completion byte not FFh
    set_scr(1, 8'hFE, 0, 0, 0, 0, 0);
    run(2'd1, 1'b0, 12'h800, 8'h00, 1, 1'b0, 1'b0, "R10 erase not FF");
    // R10: toggle stops with wrong program data
    set_scr(2, 8'h12, 8'h12, 0, 0, 0, 0);
    run(2'd0, 1'b1, 12'h055, 8'h33, 2, 1'b0, 1'b0, "R10 prog wrong");

    // R13: op 3 ignored
    rcnt = 0; wcnt = 0; done_cnt = 0;
    @(negedge clk); start = 1'b1; op = 2'd3;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    chk(wcnt == 0 && rcnt == 0 && done_cnt == 0, "R13 op3 ignored", wcnt + rcnt + done_cnt, 0);

    // R6 sweep: expected bit 7 follows the data byte
    for (int v = 0; v < 256; v += 15) begin
      logic [7:0] b;
      b = 8'(v);
      set_scr(2, {~b[7], 7'h00}, b, 0, 0, 0, 0);
      run(2'd0, 1'b0, 12'(v * 3), b, 2, 1'b1, 1'b0, "R6 sweep");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule